// File: doc/BRIEF.md
# Register File with Special-Purpose Entries

This block is the architectural register file of a small 16-bit processor core. It holds sixteen entries of 17 bits each, a 16-bit data field plus one flag bit in the top position (bit 16). Three combinational read ports serve the two source operands and the store-data operand, and one write port updates the file on the rising clock edge. Each read port has an enable. Side effects on a read happen only when that port's enable is high. The data output of a read port always shows the selected entry, whatever the enable.

Most entries are plain storage, but four indices behave differently. Entry 12 comes out of reset holding 1. Entry 13 counts down each cycle it is consumed as a source. Entry 14 is a hardware last-in-first-out stack: a write pushes and a read pops. Entry 15 stands in for the program counter: reading it returns the live PC, and writing it asks the pipeline to branch. Entries 0 to 7 have a shadow bank that takes a copy on the interrupt-entry strobe and is copied back on the interrupt-exit strobe, so an interrupt handler can use them freely.

Top module: `qreg_file`

## Requirements
- R1: After reset, entries 0–11 and 13 read 0x00000, entry 12 reads 0x00001, the stack is empty (entry 14 reads 0), and the flag held for entry 15 is 0.
- R2: A write to entries 0–12 stores all 17 bits, and any read port returns the stored value from the next cycle on. Reading these entries has no side effect.
- R3: In each cycle where entry 13 is selected with its enable on by at least one read port (a, b or s), its data field drops by exactly one. This is true even when several ports select it. The read returns the value before the decrement. The flag bit is unchanged, and 0x0000 wraps to 0xFFFF.
- R4: When entry 13 is written in a cycle where it is also read, the written value is stored and no decrement is applied.
- R5: Entry 14 returns pushed values in reverse order. A pop from an empty stack returns 0 and the stack stays empty.
- R6: The stack holds STK_DEPTH (8) entries. A push onto a full stack discards the oldest entry.
- R7: A write and a pop of entry 14 in the same cycle replace the top entry, and the read returns the old top. Pops on two ports in the same cycle count as one pop, and both ports return the same value.
- R8: Reading entry 15 returns {flag, pc_now}, where flag is bit 16 of the last value written to entry 15.
- R9: A write to entry 15 raises br_req in that same cycle, with br_target equal to wr_data[15:0]. br_req is low in every other cycle.
- R10: isr_enter copies entries 0–7 into the shadow bank. isr_exit copies the shadow bank back into entries 0–7 and leaves entries 8–15 untouched.
- R11: When isr_exit and a write to entries 0–7 fall in the same cycle, the restored value wins. When isr_enter and such a write fall in the same cycle, the shadow captures the value before the write and the live entry takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 4 | Index for read port a |
| rd_a_en | input | 1 | Port a reads as a real source (side effects on) |
| rd_a_data | output | 17 | Port a value |
| rd_b_idx | input | 4 | Index for read port b |
| rd_b_en | input | 1 | Port b reads as a real source |
| rd_b_data | output | 17 | Port b value |
| rd_s_idx | input | 4 | Index for the store-data read port |
| rd_s_en | input | 1 | Store-data port reads as a real source |
| rd_s_data | output | 17 | Store-data port value |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 17 | Write value {flag, data} |
| pc_now | input | 16 | Current program counter |
| isr_enter | input | 1 | Interrupt entry strobe |
| isr_exit | input | 1 | Interrupt exit strobe |
| br_req | output | 1 | Branch request (entry 15 written) |
| br_target | output | 16 | Branch target address |

## Verification
Several pairs of functions can fall in the same clock cycle: a write and a read of entry 13, a push and a pop of entry 14, two pops of entry 14 on different ports, and an interrupt strobe together with a write to a shadowed entry. The bench drives each pair in a single cycle. It reads the ports' values inside that cycle, and it reads the resulting state through the read ports with enables low in the following cycles. The result is judged against the priority rules in R4, R7 and R11. For example, the bench checks that entry 13 holds the written value rather than that value minus one, and that the stack depth after a simultaneous push and pop is unchanged.

// File: rtl/qreg_file.sv
module qreg_file #(
  parameter int DATA_W    = 16,
  parameter int STK_DEPTH = 8,
  parameter int SHADOW_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  input  logic              rd_a_en,
  output logic [DATA_W:0]   rd_a_data,
  input  logic [3:0]        rd_b_idx,
  input  logic              rd_b_en,
  output logic [DATA_W:0]   rd_b_data,
  input  logic [3:0]        rd_s_idx,
  input  logic              rd_s_en,
  output logic [DATA_W:0]   rd_s_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W:0]   wr_data,
  input  logic [DATA_W-1:0] pc_now,
  input  logic              isr_enter,
  input  logic              isr_exit,
  output logic              br_req,
  output logic [DATA_W-1:0] br_target
);
  localparam int RW = DATA_W + 1;
  localparam int CW = $clog2(STK_DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(STK_DEPTH);
  localparam logic [3:0] IX_DEC = 4'd13, IX_STK = 4'd14, IX_PC = 4'd15;

  logic [RW-1:0] gp [0:12];
  logic [RW-1:0] sh [0:SHADOW_N-1];
  logic [RW-1:0] stk [0:STK_DEPTH-1];
  logic [RW-1:0] r13, top;
  logic [CW-1:0] cnt;
  logic          pc_flag;

  wire wr13 = wr_en && wr_idx == IX_DEC;
  wire push = wr_en && wr_idx == IX_STK;
  wire wr15 = wr_en && wr_idx == IX_PC;
  wire dec  = (rd_a_en && rd_a_idx == IX_DEC) || (rd_b_en && rd_b_idx == IX_DEC) ||
              (rd_s_en && rd_s_idx == IX_DEC);
  wire pop  = (rd_a_en && rd_a_idx == IX_STK) || (rd_b_en && rd_b_idx == IX_STK) ||
              (rd_s_en && rd_s_idx == IX_STK);

  assign top       = (cnt == '0) ? '0 : stk[cnt - CW'(1)];
  assign br_req    = wr15;
  assign br_target = wr_data[DATA_W-1:0];

  function automatic logic [RW-1:0] pick(input logic [3:0] i);
    case (i)
      IX_DEC:  pick = r13;
      IX_STK:  pick = top;
      IX_PC:   pick = {pc_flag, pc_now};
      default: pick = gp[i];
    endcase
  endfunction

  assign rd_a_data = pick(rd_a_idx);
  assign rd_b_data = pick(rd_b_idx);
  assign rd_s_data = pick(rd_s_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 13; k++) gp[k] <= RW'(k == 12);
      for (int k = 0; k < SHADOW_N; k++) sh[k] <= '0;
    end else begin
      for (int k = 0; k < 13; k++) begin
        if (wr_en && wr_idx == 4'(k)) gp[k] <= wr_data;
        if (isr_exit && k < SHADOW_N) gp[k] <= sh[k];
      end
      if (isr_enter)
        for (int k = 0; k < SHADOW_N; k++) sh[k] <= gp[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r13     <= '0;
      pc_flag <= 1'b0;
    end else begin
      if (wr13) r13 <= wr_data;
      else if (dec) r13 <= {r13[DATA_W], r13[DATA_W-1:0] - 1'b1};
      if (wr15) pc_flag <= wr_data[DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int k = 0; k < STK_DEPTH; k++) stk[k] <= '0;
    end else if (push && pop) begin
      if (cnt == '0) begin
        stk[0] <= wr_data;
        cnt    <= CW'(1);
      end else begin
        stk[cnt - CW'(1)] <= wr_data;
      end
    end else if (push) begin
      if (cnt == FULL) begin
        for (int k = 0; k < STK_DEPTH - 1; k++) stk[k] <= stk[k+1];
        stk[STK_DEPTH-1] <= wr_data;
      end else begin
        stk[cnt] <= wr_data;
        cnt      <= cnt + CW'(1);
      end
    end else if (pop && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  a_r3_dec_once: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr13) |=> r13[DATA_W-1:0] == $past(r13[DATA_W-1:0]) - 1'b1);
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr13 |=> r13 == $past(wr_data));
  a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rd_a_idx == IX_STK) |-> rd_a_data == '0);
  a_r6_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && push && !pop) |=> cnt == FULL);
  a_r7_dual_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == IX_STK && rd_b_idx == IX_STK) |-> rd_a_data == rd_b_data);
  a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_exit && !isr_enter) |=> gp[0] == $past(sh[0]));
endmodule

// File: tb/test_qreg_file.sv
module test_qreg_file;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, rd_s_idx = 0, wr_idx = 0;
  logic rd_a_en = 0, rd_b_en = 0, rd_s_en = 0, wr_en = 0, isr_enter = 0, isr_exit = 0;
  logic [16:0] rd_a_data, rd_b_data, rd_s_data, wr_data = 0;
  logic [15:0] pc_now = 0, br_target;
  logic br_req;
  int total = 0, bad = 0;

  qreg_file i_qreg_file (.*);

  always #10 clk = ~clk;

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    rd_a_en = 0; rd_b_en = 0; rd_s_en = 0; wr_en = 0; isr_enter = 0; isr_exit = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [16:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick();
  endtask

  function automatic logic [16:0] peek(input logic [3:0] i);
    rd_a_idx = i;
    return rd_a_data;
  endfunction

  task automatic look(input string req, input logic [3:0] i, input logic [16:0] exp);
    rd_a_idx = i; #1; chk(req, rd_a_data, exp);
  endtask

  task automatic pop_a(input string req, input logic [16:0] exp);
    rd_a_idx = 14; rd_a_en = 1; #1; chk(req, rd_a_data, exp); tick();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 14; i++) look("R1 reset", 4'(i), (i == 12) ? 17'h1 : 17'h0);
    look("R1 stack empty", 14, 0);
    pc_now = 16'h0000; look("R1 pc flag", 15, 0);
  endtask

  task automatic t_plain();
    wr(3, 17'h1ABCD); wr(11, 17'h05555);
    look("R2 write r3", 3, 17'h1ABCD);
    rd_b_idx = 11; rd_b_en = 1; #1; chk("R2 port b r11", rd_b_data, 17'h05555); tick();
    look("R2 no side effect", 11, 17'h05555);
  endtask

  task automatic t_dec();
    wr(13, 17'h00005);
    rd_a_idx = 13; rd_a_en = 1; #1; chk("R3 pre-dec value", rd_a_data, 17'h00005); tick();
    look("R3 dec by one", 13, 17'h00004);
    rd_a_idx = 13; rd_b_idx = 13; rd_s_idx = 13; rd_a_en = 1; rd_b_en = 1; rd_s_en = 1; #1;
    chk("R3 port s value", rd_s_data, 17'h00004); tick();
    look("R3 single dec multi port", 13, 17'h00003);
    rd_s_idx = 13; rd_s_en = 1; tick();
    look("R3 dec via store port", 13, 17'h00002);
    wr(13, 17'h10000);
    rd_b_idx = 13; rd_b_en = 1; tick();
    look("R3 wrap keeps flag", 13, 17'h1FFFF);
  endtask

  task automatic t_dec_wr();
    wr(13, 17'h00010);
    rd_a_idx = 13; rd_a_en = 1; wr_en = 1; wr_idx = 13; wr_data = 17'h00777; #1;
    chk("R4 read old", rd_a_data, 17'h00010); tick();
    look("R4 write wins", 13, 17'h00777);
  endtask

  task automatic t_stack();
    wr(14, 17'h1); wr(14, 17'h2); wr(14, 17'h3);
    pop_a("R5 lifo 3", 17'h3); pop_a("R5 lifo 2", 17'h2); pop_a("R5 lifo 1", 17'h1);
    pop_a("R5 empty pop", 17'h0);
    look("R5 stays empty", 14, 0);
    for (int i = 1; i <= 9; i++) wr(14, 17'(i));
    for (int i = 9; i >= 2; i--) pop_a("R6 full drop oldest", 17'(i));
    pop_a("R6 oldest dropped", 17'h0);
  endtask

  task automatic t_stack_pair();
    wr(14, 17'h11); wr(14, 17'h22);
    rd_a_idx = 14; rd_a_en = 1; wr_en = 1; wr_idx = 14; wr_data = 17'h33; #1;
    chk("R7 replace reads old top", rd_a_data, 17'h22); tick();
    pop_a("R7 replaced top", 17'h33); pop_a("R7 below top kept", 17'h11);
    pop_a("R7 depth unchanged", 17'h0);
    wr(14, 17'h5); wr(14, 17'h6);
    rd_a_idx = 14; rd_b_idx = 14; rd_a_en = 1; rd_b_en = 1; #1;
    chk("R7 dual pop a", rd_a_data, 17'h6); chk("R7 dual pop b", rd_b_data, 17'h6); tick();
    pop_a("R7 single pop", 17'h5);
  endtask

  task automatic t_pc();
    pc_now = 16'h1234; look("R8 pc read", 15, 17'h01234);
    #1 chk("R9 idle no branch", {16'h0, br_req}, 17'h0);
    wr_en = 1; wr_idx = 15; wr_data = 17'h1ABCD; #1;
    chk("R9 branch req", {16'h0, br_req}, 17'h1);
    chk("R9 branch target", {1'b0, br_target}, 17'h0ABCD); tick();
    #1 chk("R9 req drops", {16'h0, br_req}, 17'h0);
    pc_now = 16'h0042; look("R8 flag from write", 15, 17'h10042);
  endtask

  task automatic t_isr();
    wr(0, 17'h00111); wr(7, 17'h10777); wr(8, 17'h00888);
    isr_enter = 1; tick();
    wr(0, 17'h00AAA); wr(7, 17'h00BBB); wr(8, 17'h00CCC);
    isr_exit = 1; tick();
    look("R10 restore r0", 0, 17'h00111);
    look("R10 restore r7", 7, 17'h10777);
    look("R10 r8 not shadowed", 8, 17'h00CCC);
  endtask

  task automatic t_isr_same();
    wr(1, 17'h00010);
    isr_enter = 1; wr_en = 1; wr_idx = 1; wr_data = 17'h00020; tick();
    look("R11 live takes write", 1, 17'h00020);
    isr_exit = 1; wr_en = 1; wr_idx = 1; wr_data = 17'h00030; tick();
    look("R11 restore wins, saved pre-write", 1, 17'h00010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_plain();
    t_dec();
    t_dec_wr();
    t_stack();
    t_stack_pair();
    t_pc();
    t_isr();
    t_isr_same();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule